// File: doc/BRIEF.md
# Chained-Frame SPI Master

This block is an SPI master that shifts out frames of 1 to 16 bits. Each frame is given to it as one transmit word holding the data, the frame length and an end-of-transfer flag. A frame without the flag does not end the transfer. The next word continues the same transfer, and the slave select stays low across the frame boundary. When the frame lengths are added together, a transfer can be any number of bits, for example 16 + 4 = 20.

The master reaches a frame boundary without the end flag. If no follow-on word is held at that point, it freezes the clock and raises `stalled`.
- In the two modes where data changes on the trailing edge, it freezes with SCK at the active level. The final trailing edge of the frame is withheld.
- In the two modes where data changes on the leading edge, it freezes with SCK idle, ahead of the first edge of the next frame.

Writing a word resumes the transfer. A one-cycle `abortReq` pulse ends the stalled transfer instead: the master completes any withheld edge, returns SCK to idle and raises the slave select.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, and whenever no transfer is running, `sck` equals `cpol`, `ssN` is 1, `stalled` is 0, `busy` is 0 and `rxValid` is 0. `txRdy` is 1 after reset.
- R2: A transmit word carries the frame data in bits 15:0, the frame length minus one in bits 19:16 (0 = 1 bit, 15 = 16 bits) and the end-of-transfer flag in bit 20. The low N data bits are sent MSB first.
- R3: With `cpha`=0, MOSI changes on trailing edges and is sampled on leading edges. With `cpha`=1, MOSI changes on leading edges and is sampled on trailing edges. A leading edge is one where SCK leaves the `cpol` level.
- R4: Each SCK half-period lasts `halfDiv`+1 clock cycles. The first edge comes `halfDiv`+1 cycles after `ssN` falls, and `ssN` rises `halfDiv`+1 cycles after the last edge.
- R5: MISO is shifted in on each sample edge. At the last sample of every frame, `rxData` presents the frame's bits right-aligned, first bit received in the highest position, and `rxValid` pulses for one cycle.
- R6: `txRdy` falls on a write of `txWrite` and rises again when the word moves into the shifter. A transfer starts only while a word is held.
- R7: A frame without the end flag whose follow-on word is already held when the boundary is reached chains on without a stall. The bit stream is continuous and `ssN` stays low.
- R8: With `cpha`=0 and no follow-on word, the master holds SCK at the non-idle level after the frame's last sample, with `stalled`=1 and `ssN`=0. It resumes with the withheld edge once a word is written.
- R9: With `cpha`=1 and no follow-on word, the master holds SCK at idle with `stalled`=1 and `ssN`=0. It resumes with the first edge of the next frame once a word is written.
- R10: An `abortReq` pulse while stalled ends the transfer: any withheld edge is completed, SCK goes idle and `ssN` rises. An `abortReq` pulse while not stalled has no effect.
- R11: A frame carrying the end flag ends the transfer after its last bit, with SCK back at `cpol` and `ssN` high.
- R12: With `enable` low, no transfer starts, and any running transfer is dropped on the next clock with SCK idle and `ssN` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| halfDiv | input | DIV_W | SCK half-period minus one, in clock cycles |
| txWrite | input | 1 | Write strobe for `txWord` |
| txWord | input | 21 | Data, length-minus-one and end flag |
| txRdy | output | 1 | Holding register is empty |
| abortReq | input | 1 | Abort request, acted on only while stalled |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Active-low slave select |
| stalled | output | 1 | Waiting for a follow-on word |
| busy | output | 1 | Transfer in progress |
| rxData | output | 16 | Last received frame, right-aligned |
| rxValid | output | 1 | One-cycle pulse when `rxData` is updated |

## Verification
The assertions check on every cycle the SCK level and slave select during a stall for each phase setting, and that the clock and select are quiet while idle. They also check that the shifter is loaded only from a full holding register, that `rxValid` is a single-cycle pulse, and that SCK moves only while the slave is selected. Only the bench's scenarios can show that the bit order, frame lengths, mode timing and divider spacing are right. The same holds for whether a follow-on word written in time avoids the stall, whether a late word resumes it with the stream intact, and whether an abort is honoured only while stalled.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int DATA_W  = 16;
  localparam int LEN_W   = 4;
  localparam int LEN_LSB = DATA_W;
  localparam int EOT_BIT = LEN_LSB + LEN_W;
  localparam int WORD_W  = EOT_BIT + 1;
  localparam int EDGE_W  = LEN_W + 1;

  // strobes from the edge sequencer to the datapath
  typedef struct packed {
    logic load;        // move holding register into shifter
    logic shift;       // advance MOSI to the next bit
    logic sample;      // capture MISO
    logic lastSample;  // this capture completes the frame
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_STALL,
    ST_TAIL
  } xferState_t;
endpackage

// File: rtl/spi_chain_datapath.sv
module spi_chain_datapath
  import spi_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               txWrite,
  input  logic [WORD_W-1:0]  txWord,
  input  dpStrobe_t          dpc,
  input  logic               miso,
  output logic               holdFull,
  output logic [LEN_W-1:0]   curLen,
  output logic               curEot,
  output logic               mosi,
  output logic [DATA_W-1:0]  rxData,
  output logic               rxValid
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_W - 1);

  logic [WORD_W-1:0] holdWord;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rxShift;

  logic [DATA_W-1:0] holdData;
  logic [LEN_W-1:0]  holdLen;
  logic              holdEot;
  logic [DATA_W-1:0] rxNext;

  assign holdData = holdWord[DATA_W-1:0];
  assign holdLen  = holdWord[LEN_LSB +: LEN_W];
  assign holdEot  = holdWord[EOT_BIT];
  assign rxNext   = {rxShift[DATA_W-2:0], miso};
  assign mosi     = shReg[DATA_W-1];

  // holding register: a write wins over a same-cycle load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      holdFull <= 1'b0;
    end else if (txWrite) begin
      holdWord <= txWord;
      holdFull <= 1'b1;
    end else if (dpc.load) begin
      holdFull <= 1'b0;
    end
  end

  // transmit shifter, MSB aligned to the top bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      curLen <= '0;
      curEot <= 1'b0;
    end else if (dpc.load) begin
      shReg  <= holdData << (MAX_LEN - holdLen);
      curLen <= holdLen;
      curEot <= holdEot;
    end else if (dpc.shift) begin
      shReg  <= shReg << 1;
    end
  end

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (dpc.load) begin
        rxShift <= '0;
      end else if (dpc.sample) begin
        rxShift <= rxNext;
        if (dpc.lastSample) begin
          rxData  <= rxNext;
          rxValid <= 1'b1;
        end
      end
    end
  end

  assert_load_has_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    dpc.load |-> holdFull);

  assert_rx_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/spi_chain_ctrl.sv
module spi_chain_ctrl
  import spi_chain_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              abortReq,
  input  logic              holdFull,
  input  logic [LEN_W-1:0]  curLen,
  input  logic              curEot,
  output dpStrobe_t         dpc,
  output logic              sckAct,
  output logic              ssAct,
  output logic              stalled,
  output logic              busy
);
  xferState_t        state, stateNx;
  logic [EDGE_W-1:0] edgeCnt, edgeNx;
  logic [DIV_W-1:0]  divCnt;
  logic              sckNx, ssNx;
  logic              abortPend;
  logic              tick;
  logic [EDGE_W-1:0] lastEdge;
  logic [EDGE_W-1:0] lastSampEdge;

  assign busy         = (state != ST_IDLE);
  assign stalled      = (state == ST_STALL);
  assign tick         = busy && (divCnt == '0);
  assign lastEdge     = {curLen, 1'b1};
  assign lastSampEdge = cpha ? lastEdge : {curLen, 1'b0};

  // half-period divider, held at reload while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       divCnt <= '0;
    else if (!busy || !enable)       divCnt <= halfDiv;
    else if (divCnt == '0)           divCnt <= halfDiv;
    else                             divCnt <= divCnt - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  abortPend <= 1'b0;
    else if (state != ST_STALL) abortPend <= 1'b0;
    else if (abortReq)          abortPend <= 1'b1;
  end

  always_comb begin
    stateNx = state;
    edgeNx  = edgeCnt;
    sckNx   = sckAct;
    ssNx    = ssAct;
    dpc     = '0;
    unique case (state)
      ST_IDLE: begin
        if (enable && holdFull) begin
          stateNx  = ST_RUN;
          ssNx     = 1'b1;
          edgeNx   = '0;
          dpc.load = !cpha;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (!cpha) begin
            if (!edgeCnt[0]) begin
              sckNx          = 1'b1;
              dpc.sample     = 1'b1;
              dpc.lastSample = (edgeCnt == lastSampEdge);
              edgeNx         = edgeCnt + EDGE_W'(1);
            end else if (edgeCnt != lastEdge) begin
              sckNx     = 1'b0;
              dpc.shift = 1'b1;
              edgeNx    = edgeCnt + EDGE_W'(1);
            end else if (curEot) begin
              sckNx   = 1'b0;
              stateNx = ST_TAIL;
            end else if (holdFull) begin
              sckNx    = 1'b0;
              dpc.load = 1'b1;
              edgeNx   = '0;
            end else begin
              stateNx = ST_STALL;
            end
          end else begin
            if (!edgeCnt[0]) begin
              if (edgeCnt != '0) begin
                sckNx     = 1'b1;
                dpc.shift = 1'b1;
                edgeNx    = edgeCnt + EDGE_W'(1);
              end else if (holdFull) begin
                sckNx    = 1'b1;
                dpc.load = 1'b1;
                edgeNx   = EDGE_W'(1);
              end else begin
                stateNx = ST_STALL;
              end
            end else begin
              sckNx          = 1'b0;
              dpc.sample     = 1'b1;
              dpc.lastSample = (edgeCnt == lastEdge);
              if (edgeCnt == lastEdge) begin
                edgeNx = '0;
                if (curEot) stateNx = ST_TAIL;
              end else begin
                edgeNx = edgeCnt + EDGE_W'(1);
              end
            end
          end
        end
      end
      ST_STALL: begin
        if (tick) begin
          if (abortPend) begin
            sckNx   = 1'b0;
            stateNx = ST_TAIL;
          end else if (holdFull) begin
            stateNx  = ST_RUN;
            dpc.load = 1'b1;
            sckNx    = cpha;
            edgeNx   = cpha ? EDGE_W'(1) : '0;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          ssNx    = 1'b0;
          stateNx = ST_IDLE;
        end
      end
    endcase
    if (!enable) begin
      stateNx = ST_IDLE;
      sckNx   = 1'b0;
      ssNx    = 1'b0;
      dpc     = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      sckAct  <= 1'b0;
      ssAct   <= 1'b0;
    end else begin
      state   <= stateNx;
      edgeCnt <= edgeNx;
      sckAct  <= sckNx;
      ssAct   <= ssNx;
    end
  end

  assert_stall_holds_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && !cpha) |-> sckAct);

  assert_stall_holds_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && cpha) |-> !sckAct);

  assert_stall_keeps_select_R7: assert property (@(posedge clk) disable iff (!rstN)
    stalled |-> ssAct);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sckAct && !ssAct));

  assert_disable_drops_R12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);
endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import spi_chain_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              txWrite,
  input  logic [WORD_W-1:0] txWord,
  output logic              txRdy,
  input  logic              abortReq,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ssN,
  output logic              stalled,
  output logic              busy,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);
  dpStrobe_t        dpc;
  logic             holdFull;
  logic [LEN_W-1:0] curLen;
  logic             curEot;
  logic             sckAct;
  logic             ssAct;

  spi_chain_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .cpha     (cpha),
    .halfDiv  (halfDiv),
    .abortReq (abortReq),
    .holdFull (holdFull),
    .curLen   (curLen),
    .curEot   (curEot),
    .dpc      (dpc),
    .sckAct   (sckAct),
    .ssAct    (ssAct),
    .stalled  (stalled),
    .busy     (busy)
  );

  spi_chain_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .txWrite  (txWrite),
    .txWord   (txWord),
    .dpc      (dpc),
    .miso     (miso),
    .holdFull (holdFull),
    .curLen   (curLen),
    .curEot   (curEot),
    .mosi     (mosi),
    .rxData   (rxData),
    .rxValid  (rxValid)
  );

  assign sck   = cpol ^ sckAct;
  assign ssN   = !ssAct;
  assign txRdy = !holdFull;

  assert_sck_only_selected_R11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $stable(cpol) && !$stable(sck)) |-> !ssN);
endmodule

// File: tb/test_spi_chain_master.sv
`timescale 1ns/1ps
module test_spi_chain_master;
  import spi_chain_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic cpol = 1'b0;
  logic cpha = 1'b0;
  logic [7:0] halfDiv = 8'd1;
  logic txWrite = 1'b0;
  logic [WORD_W-1:0] txWord = '0;
  logic txRdy;
  logic abortReq = 1'b0;
  logic miso = 1'b0;
  logic sck, mosi, ssN, stalled, busy, rxValid;
  logic [DATA_W-1:0] rxData;

  always #4 clk = ~clk;

  spi_chain_master #(.DIV_W(8)) i_spi_chain_master (
    .clk(clk), .rstN(rstN), .enable(enable), .cpol(cpol), .cpha(cpha),
    .halfDiv(halfDiv), .txWrite(txWrite), .txWord(txWord), .txRdy(txRdy),
    .abortReq(abortReq), .miso(miso), .sck(sck), .mosi(mosi), .ssN(ssN),
    .stalled(stalled), .busy(busy), .rxData(rxData), .rxValid(rxValid)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave-side monitor, per transfer state reset on ssN fall
  logic [31:0] misoStream = 32'h0;
  logic [63:0] capBits;
  int capCnt = 0, rxN = 0, stallCyc = 0, mIdx = 0;
  logic [DATA_W-1:0] rxLog [4];
  logic stallSck = 1'b0;
  logic prevSck = 1'b0, prevSs = 1'b1;
  int tFall = 0, tFirst = -1, tLast = 0, tRise = 0, minGap = 0, maxGap = 0;

  always @(negedge clk) begin
    logic lead;
    int gap;
    if (rxValid) begin
      if (rxN < 4) rxLog[rxN] = rxData;
      rxN++;
    end
    if (!ssN && prevSs) begin
      capBits = '0; capCnt = 0; rxN = 0; stallCyc = 0;
      tFall = cyc; tFirst = -1; minGap = 1000000; maxGap = 0;
      if (!cpha) begin miso = misoStream[31]; mIdx = 1; end
      else mIdx = 0;
    end
    if (ssN && !prevSs) tRise = cyc;
    if (stalled) begin stallCyc++; stallSck = sck; end
    if (!ssN && sck !== prevSck) begin
      lead = (prevSck == cpol);
      if (tFirst < 0) tFirst = cyc;
      else begin
        gap = cyc - tLast;
        if (gap < minGap) minGap = gap;
        if (gap > maxGap) maxGap = gap;
      end
      tLast = cyc;
      if (cpha ? !lead : lead) begin
        capBits = {capBits[62:0], mosi};
        capCnt++;
      end else if (mIdx < 32) begin
        miso = misoStream[31 - mIdx];
        mIdx++;
      end
    end
    prevSck = sck;
    prevSs = ssN;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] mkWord(input logic [15:0] d, input int n,
                                                input logic eot);
    return {eot, 4'(n - 1), d};
  endfunction

  function automatic logic [15:0] streamBits(input int off, input int n);
    logic [31:0] v;
    v = misoStream >> (32 - off - n);
    v = v & ((32'h1 << n) - 32'h1);
    return v[15:0];
  endfunction

  function automatic logic [63:0] lowMask(input int n);
    return (64'h1 << n) - 64'h1;
  endfunction

  task automatic writeWord(input logic [WORD_W-1:0] w);
    txWord = w;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic waitIdle();
    int to = 0;
    repeat (3) @(negedge clk);
    while (busy && to < 5000) begin @(negedge clk); to++; end
    @(negedge clk);
  endtask

  task automatic waitStall();
    int to = 0;
    while (!stalled && to < 5000) begin @(negedge clk); to++; end
  endtask

  task automatic waitTxRdy();
    int to = 0;
    while (!txRdy && to < 5000) begin @(negedge clk); to++; end
  endtask

  task automatic pulseAbort();
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog (all R): actual hung expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] d1, d2;
    logic [63:0] expBits;
    logic holdSck;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sck == 1'b0 && ssN && txRdy && !stalled && !rxValid && !busy,
          "R1", "reset outputs", {sck, ssN, txRdy, stalled, rxValid, busy}, 6'b011000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    check(sck == 1'b1 && ssN, "R1", "idle sck with cpol=1", sck, 1);

    // R2 R3 R5 R11: sweep of all modes and every frame length
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      repeat (2) @(negedge clk);
      for (int n = 1; n <= 16; n++) begin
        d1 = 16'((32'hB2E7 + n * 32'h1357 + m * 32'h0F0F) & lowMask(n));
        misoStream = 32'h9E3779B9 * (n + m * 17);
        writeWord(mkWord(d1, n, 1'b1));
        waitIdle();
        check(capCnt == n && (capBits & lowMask(n)) == 64'(d1), "R2",
              $sformatf("mode%0d len%0d mosi bits (R3)", m, n), capBits, d1);
        check(rxN == 1 && rxLog[0] == streamBits(0, n), "R5",
              $sformatf("mode%0d len%0d rx", m, n), rxLog[0], streamBits(0, n));
        check(ssN && sck == cpol && stallCyc == 0, "R11",
              $sformatf("mode%0d len%0d end state", m, n), {ssN, sck}, {1'b1, cpol});
      end
    end

    // R7: 16 + 4 bit chained transfer, second word written in time
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      misoStream = 32'hC3A5_1E69 + m;
      d1 = 16'hA53C ^ 16'(m);
      d2 = 16'h0009;
      repeat (2) @(negedge clk);
      writeWord(mkWord(d1, 16, 1'b0));
      repeat (2) @(negedge clk);
      waitTxRdy();
      writeWord(mkWord(d2, 4, 1'b1));
      waitIdle();
      expBits = {44'h0, d1, d2[3:0]};
      check(capCnt == 20 && (capBits & lowMask(20)) == expBits, "R7",
            $sformatf("mode%0d 20-bit stream", m), capBits & lowMask(20), expBits);
      check(stallCyc == 0, "R7", $sformatf("mode%0d no stall", m), stallCyc, 0);
      check(rxN == 2 && rxLog[0] == streamBits(0, 16) && rxLog[1] == streamBits(16, 4),
            "R5", $sformatf("mode%0d chained rx", m), rxLog[1], streamBits(16, 4));
    end

    // R8 R9: late second word causes a stall, then resumes
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      misoStream = 32'h5A0F_C396 ^ (m * 32'h1111);
      d1 = 16'h00B4;
      d2 = 16'h0013;
      repeat (2) @(negedge clk);
      writeWord(mkWord(d1, 8, 1'b0));
      waitStall();
      holdSck = cpha ? cpol : !cpol;
      check(stalled && sck == holdSck && !ssN && capCnt == 8,
            cpha ? "R9" : "R8", $sformatf("mode%0d stall level", m), sck, holdSck);
      repeat (20) @(negedge clk);
      check(stalled && sck == holdSck && capCnt == 8 && rxN == 1,
            cpha ? "R9" : "R8", $sformatf("mode%0d stall held", m), capCnt, 8);
      writeWord(mkWord(d2, 5, 1'b1));
      waitIdle();
      expBits = {48'h0, d1[7:0], d2[4:0]};
      check(capCnt == 13 && (capBits & lowMask(13)) == expBits,
            cpha ? "R9" : "R8", $sformatf("mode%0d resumed stream", m),
            capBits & lowMask(13), expBits);
      check(rxN == 2 && rxLog[1] == streamBits(8, 5), "R5",
            $sformatf("mode%0d rx after stall", m), rxLog[1], streamBits(8, 5));
    end

    // R10: abort while stalled, both phases
    for (int ph = 0; ph < 2; ph++) begin
      cpol = 1'b1; cpha = ph[0];
      repeat (2) @(negedge clk);
      writeWord(mkWord(16'h002D, 6, 1'b0));
      waitStall();
      pulseAbort();
      waitIdle();
      check(ssN && sck == cpol && !busy && !stalled && txRdy && capCnt == 6, "R10",
            $sformatf("cpha%0d abort ends transfer", ph), {ssN, sck, busy}, 3'b110);
    end

    // R10: abort while running is ignored
    cpol = 1'b0; cpha = 1'b0;
    repeat (2) @(negedge clk);
    writeWord(mkWord(16'hF00D, 16, 1'b0));
    repeat (10) @(negedge clk);
    pulseAbort();
    repeat (4) @(negedge clk);
    check(busy && !ssN, "R10", "abort while running ignored", busy, 1);
    waitStall();
    check(stalled && capCnt == 16, "R10", "transfer reached stall after ignored abort",
          capCnt, 16);
    pulseAbort();
    waitIdle();
    check(ssN && !busy, "R10", "abort after stall", ssN, 1);

    // R4: divider spacing with halfDiv = 3
    halfDiv = 8'd3;
    writeWord(mkWord(16'h0005, 3, 1'b1));
    waitIdle();
    check(tFirst - tFall == 4, "R4", "select setup cycles", tFirst - tFall, 4);
    check(minGap == 4 && maxGap == 4, "R4", "half-period cycles", maxGap, 4);
    check(tRise - tLast == 4, "R4", "select hold cycles", tRise - tLast, 4);
    halfDiv = 8'd1;

    // R12 R6: enable gating and holding register flag
    enable = 1'b0;
    @(negedge clk);
    writeWord(mkWord(16'h1234, 16, 1'b1));
    repeat (10) @(negedge clk);
    check(ssN && !busy && !txRdy, "R12", "no start while disabled (R6 txRdy low)",
          {ssN, busy, txRdy}, 3'b100);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    check(busy && txRdy, "R6", "txRdy set after word moved to shifter", {busy, txRdy}, 2'b11);
    repeat (8) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(ssN && sck == cpol && !busy, "R12", "disable drops transfer", {ssN, busy}, 2'b10);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    check(ssN && !busy, "R12", "no restart without a word", busy, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule